// File: doc/BRIEF.md
# Chainable Triple Down-Count Timer

The block holds three independent 16-bit down-counters behind a small synchronous register port. Each counter has a control word, a preload value that software can write but not read back, a count register it can both read and write, and a sticky overflow flag. While a counter is enabled, every tick of its chosen source takes one off the count. On the first tick after the count has reached zero the counter overflows. It then reloads from its preload value, drives a one-cycle overflow pulse and sets its flag.

Each counter picks its tick from one of four sources: the system clock divided by four, an external prescaler strobe, the overflow pulse of the counter below it, or a synchronized external event pin. Chaining counters this way builds a wider counter or a cascaded divider. The lowest counter has nothing below it, so the chain source gives it no ticks. The block combines the flags with their per-counter enables into one interrupt line.

Register map: address = 4*n + r for counter n. r=0 is control: bit0 enable, bit1 interrupt enable, bits[3:2] source. r=1 is preload. r=2 is count. r=3 is status, with bit0 the overflow flag.

Top module: `cascade_timer`

## Requirements
- R1: Source code 00 ticks the counter once in every four system clock cycles.
- R2: Source code 01 ticks the counter once per clock cycle in which `pre_tick` is high. A disabled counter (control bit0 = 0) never changes its count on a tick.
- R3: Source code 11 passes `ev_in[n]` through two synchronizing flops. Each rising edge gives exactly one tick, and the count drops on the third clock edge after the pin rises. A pin held high gives no further ticks.
- R4: Source code 10 ticks counter n (n>0) once for each overflow pulse of counter n-1. The pulse is taken one cycle after the overflow, and counter 0 with code 10 never counts.
- R5: A preload write made while the counter is disabled also loads the count. The exception is when the count register has been written directly since the counter was last enabled; in that case the count keeps its value.
- R6: A preload write made while the counter is enabled is ignored, and the next reload uses the old value.
- R7: A tick at count zero reloads the count from preload, drives `tmr_ovf[n]` high for one cycle and sets the status flag. A tick at a nonzero count subtracts one.
- R8: Writing 1 to status bit0 clears the flag, and writing 0 leaves it. `irq` is high when any counter has both its flag and its interrupt enable (control bit1) set.
- R9: Control bits above bit3 and status bits above bit0 read as zero and cannot be set. A read of a preload address returns zero.
- R10: After reset, all counts, preloads, control words and flags are zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pre_tick | input | 1 | Prescaler strobe shared by all counters |
| ev_in | input | 3 | Asynchronous external event pins, one per counter |
| tmr_ovf | output | 3 | One-cycle overflow pulse per counter |
| irq | output | 1 | Combined interrupt request |

## Verification
On every cycle, assertions check several properties: the one-step decrement on a nonzero tick, the reload and flag set at zero, that a preload does not change while its counter is enabled, that a disabled counter holds its count, and that counter 0 stays still when it selects the chain source. Some behaviour spans many cycles or concerns what is visible at the ports, and only the directed scenarios show it. These are the one-in-four cadence of the divided clock, the three-edge latency of the event synchronizer, the one-cycle delay through the chain, and the rule that a direct count write blocks the preload copy. The scenarios also cover flag clearing, interrupt masking and reserved-bit readback.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;
   typedef enum logic [1:0] {
      SRC_DIV   = 2'b00,
      SRC_PRE   = 2'b01,
      SRC_CHAIN = 2'b10,
      SRC_EXT   = 2'b11
   } src_e;

   localparam logic [1:0] REG_CTRL = 2'd0;
   localparam logic [1:0] REG_LOAD = 2'd1;
   localparam logic [1:0] REG_CNT  = 2'd2;
   localparam logic [1:0] REG_STAT = 2'd3;

   localparam int CTRL_BITS = 4;
endpackage

// File: rtl/ctimer_div.sv
module ctimer_div #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int W = (DIV > 2) ? $clog2(DIV) : 1;

   if (DIV < 2) begin : g_bad_div
      $error("ctimer_div: DIV must be at least 2");
   end

   logic [W-1:0] phase;

   assign tick = (phase == W'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    phase <= '0;
      else if (tick) phase <= '0;
      else           phase <= phase + 1'b1;
   end
endmodule

// File: rtl/ctimer_edge.sv
module ctimer_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ctimer_edge: STAGES must be at least 2");
   end

   logic [STAGES:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-1:0], pin};
   end

   assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ctimer_chan.sv
module ctimer_chan
   import ctimer_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic              load_we,
   input  logic              cnt_we,
   input  logic              stat_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              div_tick,
   input  logic              pre_tick,
   input  logic              chain_tick,
   input  logic              ext_tick,
   output logic              en_o,
   output logic              ie_o,
   output src_e              src_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              flag_o,
   output logic              ovf_o
);
   if (CNT_W > DATA_W) begin : g_bad_width
      $error("ctimer_chan: CNT_W must not exceed DATA_W");
   end

   logic             en, ie, direct, flag, ovf;
   src_e             src;
   logic [CNT_W-1:0] load_r, cnt_r;
   logic             tick, fire, zero;

   always_comb begin
      unique case (src)
         SRC_DIV:   tick = div_tick;
         SRC_PRE:   tick = pre_tick;
         SRC_CHAIN: tick = chain_tick;
         default:   tick = ext_tick;
      endcase
   end

   assign zero = (cnt_r == '0);
   assign fire = en & tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         ie     <= 1'b0;
         src    <= SRC_DIV;
         direct <= 1'b0;
         flag   <= 1'b0;
         ovf    <= 1'b0;
         load_r <= '0;
         cnt_r  <= '0;
      end else begin
         ovf <= 1'b0;
         if (ctrl_we) begin
            en  <= wdata[0];
            ie  <= wdata[1];
            src <= src_e'(wdata[3:2]);
            if (wdata[0] && !en) direct <= 1'b0;
         end
         if (load_we && !en) begin
            load_r <= wdata[CNT_W-1:0];
            if (!direct) cnt_r <= wdata[CNT_W-1:0];
         end
         if (fire) begin
            if (zero) begin
               cnt_r <= load_r;
               ovf   <= 1'b1;
            end else begin
               cnt_r <= cnt_r - 1'b1;
            end
         end
         if (cnt_we) begin
            cnt_r  <= wdata[CNT_W-1:0];
            direct <= 1'b1;
         end
         if (stat_we && wdata[0]) flag <= 1'b0;
         if (fire && zero)        flag <= 1'b1;
      end
   end

   assign en_o   = en;
   assign ie_o   = ie;
   assign src_o  = src;
   assign cnt_o  = cnt_r;
   assign flag_o = flag;
   assign ovf_o  = ovf;

   a_r7_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !zero && !cnt_we) |=> (cnt_r == $past(cnt_r) - 1'b1));

   a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && zero && !cnt_we) |=> ((cnt_r == $past(load_r)) && ovf && flag));

   a_r6_preload_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (en && load_we) |=> $stable(load_r));

   a_r2_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !cnt_we && !load_we) |=> $stable(cnt_r));
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
   import ctimer_pkg::*;
#(
   parameter int NUM_TMR = 3,
   parameter int CNT_W   = 16,
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 4,
   parameter int DIV     = 4,
   parameter int SYNC    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              pre_tick,
   input  logic [NUM_TMR-1:0] ev_in,
   output logic [NUM_TMR-1:0] tmr_ovf,
   output logic              irq
);
   localparam int IDX_W = ADDR_W - 2;

   if (NUM_TMR < 1) begin : g_bad_num
      $error("cascade_timer: NUM_TMR must be at least 1");
   end
   if (ADDR_W < $clog2(NUM_TMR) + 2) begin : g_bad_addr
      $error("cascade_timer: ADDR_W too small for NUM_TMR");
   end
   if (DATA_W < CTRL_BITS) begin : g_bad_data
      $error("cascade_timer: DATA_W too small for control word");
   end

   logic [IDX_W-1:0] idx;
   logic [1:0]       rsel;
   logic             div_tick;

   assign idx  = bus_addr[ADDR_W-1:2];
   assign rsel = bus_addr[1:0];

   logic [NUM_TMR-1:0] en_w, ie_w, flag_w, ext_w, cnt_we_w;
   src_e               src_w [NUM_TMR];
   logic [CNT_W-1:0]   cnt_w [NUM_TMR];

   ctimer_div #(.DIV(DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .tick(div_tick)
   );

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_ch
      logic hit, chain_in;

      assign hit         = bus_we && (idx == IDX_W'(i));
      assign cnt_we_w[i] = hit && (rsel == REG_CNT);

      if (i == 0) begin : g_head
         assign chain_in = 1'b0;
      end else begin : g_link
         assign chain_in = tmr_ovf[i-1];
      end

      ctimer_edge #(.STAGES(SYNC)) u_sync (
         .clk(clk), .rst_n(rst_n), .pin(ev_in[i]), .rise(ext_w[i])
      );

      ctimer_chan #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .ctrl_we    (hit && (rsel == REG_CTRL)),
         .load_we    (hit && (rsel == REG_LOAD)),
         .cnt_we     (cnt_we_w[i]),
         .stat_we    (hit && (rsel == REG_STAT)),
         .wdata      (bus_wdata),
         .div_tick   (div_tick),
         .pre_tick   (pre_tick),
         .chain_tick (chain_in),
         .ext_tick   (ext_w[i]),
         .en_o       (en_w[i]),
         .ie_o       (ie_w[i]),
         .src_o      (src_w[i]),
         .cnt_o      (cnt_w[i]),
         .flag_o     (flag_w[i]),
         .ovf_o      (tmr_ovf[i])
      );
   end

   assign irq = |(flag_w & ie_w);

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_TMR; i++) begin
         if (idx == IDX_W'(i)) begin
            unique case (rsel)
               REG_CTRL: bus_rdata[CTRL_BITS-1:0] = {src_w[i], ie_w[i], en_w[i]};
               REG_CNT:  bus_rdata[CNT_W-1:0]     = cnt_w[i];
               REG_STAT: bus_rdata[0]             = flag_w[i];
               default:  bus_rdata                = '0;
            endcase
         end
      end
   end

   a_r4_head_chain_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (en_w[0] && (src_w[0] == SRC_CHAIN) && !cnt_we_w[0]) |=> $stable(cnt_w[0]));

   a_r4_head_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (en_w[0] && (src_w[0] == SRC_CHAIN)) |=> !tmr_ovf[0]);
endmodule

// File: tb/tb_cascade_timer.sv
`timescale 1ns/1ps
module tb_cascade_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        pre_tick = 1'b0;
   logic [2:0]  ev_in = '0;
   logic [2:0]  tmr_ovf;
   logic        irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   cascade_timer dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pre_tick(pre_tick),
      .ev_in(ev_in), .tmr_ovf(tmr_ovf), .irq(irq)
   );

   function automatic logic [3:0] ad(int t, int r);
      return 4'(t * 4 + r);
   endfunction

   task automatic chk(string req, int got, int exp);
      n_run++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; pre_tick = 1'b0; ev_in = '0; bus_we = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(logic [3:0] a, logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output int v);
      bus_addr = a;
      #1 v = int'(bus_rdata);
   endtask

   task automatic pulse();
      @(negedge clk);
      pre_tick = 1'b1;
      @(negedge clk);
      pre_tick = 1'b0;
   endtask

   task automatic t_reset();
      int v;
      do_reset();
      for (int t = 0; t < 3; t++) begin
         rd(ad(t, 2), v); chk("R10 count", v, 0);
         rd(ad(t, 0), v); chk("R10 ctrl", v, 0);
         rd(ad(t, 3), v); chk("R10 flag", v, 0);
      end
      chk("R10 irq", irq, 0);
   endtask

   task automatic t_prescaler();
      int v;
      do_reset();
      wr(ad(1, 1), 16'd3);
      rd(ad(1, 2), v); chk("R5 preload copy", v, 3);
      wr(ad(1, 0), 16'h0007);
      pulse();
      rd(ad(1, 2), v); chk("R2 one tick", v, 2);
      pulse(); pulse();
      rd(ad(1, 2), v); chk("R7 reach zero", v, 0);
      chk("R7 no ovf at zero", tmr_ovf[1], 0);
      pulse();
      rd(ad(1, 2), v); chk("R7 reload", v, 3);
      chk("R7 ovf pulse", tmr_ovf[1], 1);
      rd(ad(1, 3), v); chk("R7 flag set", v, 1);
      chk("R8 irq high", irq, 1);
      @(negedge clk);
      chk("R7 ovf one cycle", tmr_ovf[1], 0);
      wr(ad(1, 3), 16'h0000);
      rd(ad(1, 3), v); chk("R8 write 0 keeps", v, 1);
      wr(ad(1, 3), 16'h0001);
      rd(ad(1, 3), v); chk("R8 w1c", v, 0);
      chk("R8 irq low", irq, 0);
      wr(ad(1, 0), 16'h0006);
      pulse(); pulse();
      rd(ad(1, 2), v); chk("R2 disabled hold", v, 3);
   endtask

   task automatic t_lock();
      int v;
      do_reset();
      wr(ad(2, 1), 16'd5);
      wr(ad(2, 0), 16'h0005);
      wr(ad(2, 1), 16'd9);
      repeat (5) pulse();
      rd(ad(2, 2), v); chk("R6 at zero", v, 0);
      pulse();
      rd(ad(2, 2), v); chk("R6 old preload", v, 5);
      rd(ad(2, 3), v); chk("R8 flag set", v, 1);
      chk("R8 masked irq", irq, 0);
      wr(ad(2, 0), 16'h0000);
      wr(ad(2, 2), 16'd20);
      wr(ad(2, 1), 16'd7);
      rd(ad(2, 2), v); chk("R5 direct blocks", v, 20);
      wr(ad(2, 0), 16'h0009);
      wr(ad(2, 0), 16'h0000);
      wr(ad(2, 1), 16'd7);
      rd(ad(2, 2), v); chk("R5 copy after enable", v, 7);
   endtask

   task automatic t_chain();
      int v;
      do_reset();
      wr(ad(1, 1), 16'd2);
      wr(ad(1, 0), 16'h0009);
      wr(ad(0, 1), 16'd1);
      wr(ad(0, 0), 16'h0005);
      pulse();
      rd(ad(1, 2), v); chk("R4 no pre tick on chained", v, 2);
      pulse();
      chk("R4 head ovf", tmr_ovf[0], 1);
      rd(ad(1, 2), v); chk("R4 one cycle later", v, 2);
      @(negedge clk);
      rd(ad(1, 2), v); chk("R4 chained tick", v, 1);
      do_reset();
      wr(ad(0, 1), 16'd4);
      wr(ad(0, 0), 16'h0009);
      repeat (6) pulse();
      repeat (10) @(negedge clk);
      rd(ad(0, 2), v); chk("R4 head chain idle", v, 4);
   endtask

   task automatic t_div();
      int a, b, c;
      do_reset();
      wr(ad(0, 1), 16'd100);
      wr(ad(0, 0), 16'h0001);
      rd(ad(0, 2), a);
      repeat (4) @(negedge clk);
      rd(ad(0, 2), b);
      chk("R1 one per four", a - b, 1);
      repeat (8) @(negedge clk);
      rd(ad(0, 2), c);
      chk("R1 three per twelve", a - c, 3);
   endtask

   task automatic t_ext();
      int v;
      do_reset();
      wr(ad(2, 1), 16'd10);
      wr(ad(2, 0), 16'h000D);
      ev_in[2] = 1'b1;
      repeat (2) @(negedge clk);
      rd(ad(2, 2), v); chk("R3 sync latency", v, 10);
      @(negedge clk);
      rd(ad(2, 2), v); chk("R3 third edge", v, 9);
      repeat (6) @(negedge clk);
      rd(ad(2, 2), v); chk("R3 held high", v, 9);
      ev_in[2] = 1'b0;
      repeat (3) @(negedge clk);
      ev_in[2] = 1'b1;
      repeat (3) @(negedge clk);
      rd(ad(2, 2), v); chk("R3 second edge", v, 8);
   endtask

   task automatic t_reserved();
      int v;
      do_reset();
      wr(ad(1, 0), 16'hFFF2);
      rd(ad(1, 0), v); chk("R9 ctrl reserved", v, 2);
      wr(ad(1, 1), 16'h1234);
      rd(ad(1, 1), v); chk("R9 preload reads zero", v, 0);
      wr(ad(1, 3), 16'hFFFE);
      rd(ad(1, 3), v); chk("R9 status reserved", v, 0);
   endtask

   initial begin
      t_reset();
      t_prescaler();
      t_lock();
      t_chain();
      t_div();
      t_ext();
      t_reserved();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule